// File: doc/BRIEF.md
# Reset Pin and Boot-Mode Controller

This block owns a shared package pin that starts life as a general-purpose I/O and can be turned into an active-low, open-drain reset pin by software. Once turned on, the reset function stays on until the next power-on reset. While it is on, a low level applied from outside resets the system. Every reset that is not a power-on reset also pulls the pin low for a fixed number of bus cycles, so that external devices on the same reset net are reset as well.

The block also records why each reset happened, in a one-hot status register. It controls the enable of a second shared pin that carries debug communication and the boot-mode strap. When the internal reset is released after a power-on reset or a debug-forced reset, the strap level on that second pin is latched to select debug mode or normal mode. Every other kind of reset selects normal mode and ignores the strap.

The internal reset, `rst_n_int`, is active low. Its rising edge, called release below, happens only after the low-drive stretch has finished and the pin reads high again.

Top module: `rstpin_ctrl`

## Requirements
- R1: While `por_n` is low and on the first cycle after it rises, the block sets `rst_pin_en` to 0, sets `bkgd_pin_en` to 1 and sets `rst_status` to 6'b000001. While `rst_pin_en` is 0, a low level on `pin_in` causes no reset.
- R2: A configuration write with `cfg_rst_pin_en`=1 sets `rst_pin_en`. After that, writes of 0 leave it at 1, and only `por_n` clears it.
- R3: While `rst_pin_en` is 1, a low level on `pin_in` that lasts at least 3 clock cycles starts a reset with the pin cause. `pin_in` passes through a two-flop synchronizer before it is used.
- R4: A reset that is not a power-on reset holds `pin_drive_low` high for exactly `STRETCH_CYC` cycles in which `bus_en` is 1, when `rst_pin_en` is 1. When `rst_pin_en` is 0, `pin_drive_low` stays 0.
- R5: `rst_status` is always one-hot. Each reset replaces it with one bit: bit 0 power-on, bit 1 pin, bit 2 watchdog, bit 3 illegal opcode, bit 4 low voltage, bit 5 debug force. `int_rst_code` values 2, 3 and 4 select bits 2, 3 and 4. Any other value is recorded as illegal opcode, bit 3.
- R6: Every reset sets `bkgd_pin_en` to 1. A configuration write outside reset loads it from `cfg_bkgd_en`.
- R7: At release after a power-on reset or a debug-force reset, `dbg_mode` becomes the inverse of `mode_pin`: low selects debug mode (1) and high selects normal mode (0).
- R8: At release after a pin, watchdog, illegal-opcode or low-voltage reset, `dbg_mode` becomes 0 whatever `mode_pin` is.
- R9: The low level that the block itself drives on the pin is never recorded as a new pin reset.
- R10: `rst_n_int` stays 0 until the stretch has finished and the synchronized pin reads high. If the pin is held low from outside, the reset is held for as long as the pin stays low.
- R11: Requests that arrive in the same cycle are taken in this order: debug force first, then the internal request, then the pin. Requests and configuration writes that arrive while `rst_n_int` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| bus_en | input | 1 | Bus-cycle enable; the stretch counts only cycles in which it is 1 |
| int_rst_req | input | 1 | Internal reset request, one cycle |
| int_rst_code | input | 3 | Cause code of the internal request |
| dbg_force_req | input | 1 | Debug force-reset request, one cycle |
| pin_in | input | 1 | Level read back from the shared reset pin |
| mode_pin | input | 1 | Level of the boot-mode strap pin |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rst_pin_en | input | 1 | Write data for the reset-pin enable |
| cfg_bkgd_en | input | 1 | Write data for the debug-pin enable |
| rst_n_int | output | 1 | Internal system reset, active low |
| pin_drive_low | output | 1 | Open-drain pull-down enable for the reset pin |
| rst_status | output | 6 | One-hot record of the last reset cause |
| rst_pin_en | output | 1 | Reset function of the shared pin is enabled |
| bkgd_pin_en | output | 1 | Debug/strap function of the second pin is enabled |
| dbg_mode | output | 1 | Boot mode latched at release: 1 = debug, 0 = normal |

## Verification
The bench builds the block with `STRETCH_CYC` = 6, so each stretch lasts only a few cycles. This keeps a full sweep short enough to run. The sweep covers all eight internal cause codes, each under three `bus_en` duty patterns, so both the code mapping and the gating of the stretch by `bus_en` are checked. The short stretch also leaves room to hold the pin low from outside for much longer than the stretch, to try both strap levels after power-on and after debug-force resets, and to send requests that coincide in the same cycle.

// File: rtl/rstpin_pkg.sv
package rstpin_pkg;
  localparam int NUM_CAUSES = 6;

  typedef enum logic [2:0] {
    CS_POR  = 3'd0,
    CS_PIN  = 3'd1,
    CS_WDOG = 3'd2,
    CS_ILOP = 3'd3,
    CS_LVD  = 3'd4,
    CS_DBG  = 3'd5
  } cause_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_STRETCH,
    ST_SETTLE
  } seq_e;

  // One-hot status word for a cause.
  function automatic logic [NUM_CAUSES-1:0] cause_bit(cause_e c);
    logic [NUM_CAUSES-1:0] v;
    v = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  // Internal request codes: watchdog, illegal opcode and low voltage pass through.
  // Every other value is recorded as illegal opcode.
  function automatic cause_e map_internal(logic [2:0] code);
    case (code)
      3'd2, 3'd3, 3'd4: return cause_e'(code);
      default:          return CS_ILOP;
    endcase
  endfunction
endpackage

// File: rtl/rstpin_sync.sv
module rstpin_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= {STAGES{RST_VAL}};
    else         chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rstpin_arb.sv
module rstpin_arb
  import rstpin_pkg::*;
(
  input  logic       in_run,
  input  logic       dbg_req,
  input  logic       int_req,
  input  logic [2:0] int_code,
  input  logic       pin_low_evt,
  output logic       evt,
  output cause_e     evt_cause
);
  always_comb begin
    evt       = 1'b0;
    evt_cause = CS_POR;
    if (in_run) begin
      if (dbg_req) begin
        evt       = 1'b1;
        evt_cause = CS_DBG;
      end else if (int_req) begin
        evt       = 1'b1;
        evt_cause = map_internal(int_code);
      end else if (pin_low_evt) begin
        evt       = 1'b1;
        evt_cause = CS_PIN;
      end
    end
  end
endmodule

// File: rtl/rstpin_seq.sv
module rstpin_seq
  import rstpin_pkg::*;
#(
  parameter int STRETCH_CYC = 66
) (
  input  logic   clk,
  input  logic   por_n,
  input  logic   bus_en,
  input  logic   evt,
  input  cause_e evt_cause,
  input  logic   pin_en,
  input  logic   pin_high,
  output logic   in_run,
  output logic   drive_low,
  output logic   release_evt,
  output logic   sample_mode
);
  localparam int CNT_W = $clog2(STRETCH_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STRETCH_CYC - 1);

  seq_e             st;
  logic [CNT_W-1:0] cnt;
  logic             stretch_done;

  assign stretch_done = (st == ST_STRETCH) && bus_en && (cnt == LAST);
  assign release_evt  = (st == ST_SETTLE) && (!pin_en || pin_high);
  assign in_run       = (st == ST_RUN);
  assign drive_low    = (st == ST_STRETCH);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st          <= ST_SETTLE;
      cnt         <= '0;
      sample_mode <= 1'b1;
    end else begin
      case (st)
        ST_RUN: if (evt) begin
          st          <= pin_en ? ST_STRETCH : ST_SETTLE;
          cnt         <= '0;
          sample_mode <= (evt_cause == CS_DBG);
        end
        ST_STRETCH: begin
          if (stretch_done)     st  <= ST_SETTLE;
          else if (bus_en)      cnt <= cnt + 1'b1;
        end
        ST_SETTLE: if (release_evt) st <= ST_RUN;
        default: st <= ST_SETTLE;
      endcase
    end
  end
endmodule

// File: rtl/rstpin_ctrl.sv
module rstpin_ctrl
  import rstpin_pkg::*;
#(
  parameter int STRETCH_CYC = 66
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  bus_en,
  input  logic                  int_rst_req,
  input  logic [2:0]            int_rst_code,
  input  logic                  dbg_force_req,
  input  logic                  pin_in,
  input  logic                  mode_pin,
  input  logic                  cfg_wr,
  input  logic                  cfg_rst_pin_en,
  input  logic                  cfg_bkgd_en,
  output logic                  rst_n_int,
  output logic                  pin_drive_low,
  output logic [NUM_CAUSES-1:0] rst_status,
  output logic                  rst_pin_en,
  output logic                  bkgd_pin_en,
  output logic                  dbg_mode
);
  logic   pin_sync;
  logic   pin_low_evt;
  logic   in_run;
  logic   evt;
  cause_e evt_cause;
  logic   release_evt;
  logic   sample_mode;

  rstpin_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .arst_n(por_n), .d(pin_in), .q(pin_sync)
  );

  assign pin_low_evt = rst_pin_en && !pin_sync;

  rstpin_arb u_arb (
    .in_run(in_run), .dbg_req(dbg_force_req), .int_req(int_rst_req),
    .int_code(int_rst_code), .pin_low_evt(pin_low_evt),
    .evt(evt), .evt_cause(evt_cause)
  );

  rstpin_seq #(.STRETCH_CYC(STRETCH_CYC)) u_seq (
    .clk(clk), .por_n(por_n), .bus_en(bus_en), .evt(evt), .evt_cause(evt_cause),
    .pin_en(rst_pin_en), .pin_high(pin_sync), .in_run(in_run),
    .drive_low(pin_drive_low), .release_evt(release_evt), .sample_mode(sample_mode)
  );

  assign rst_n_int = in_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_pin_en  <= 1'b0;
      bkgd_pin_en <= 1'b1;
      rst_status  <= cause_bit(CS_POR);
      dbg_mode    <= 1'b0;
    end else begin
      if (evt) begin
        rst_status  <= cause_bit(evt_cause);
        bkgd_pin_en <= 1'b1;
      end else if (cfg_wr && in_run) begin
        rst_pin_en  <= rst_pin_en | cfg_rst_pin_en;
        bkgd_pin_en <= cfg_bkgd_en;
      end
      if (release_evt) dbg_mode <= sample_mode ? ~mode_pin : 1'b0;
    end
  end
endmodule

// File: rtl/rstpin_ctrl_chk.sv
module rstpin_ctrl_chk #(
  parameter int STRETCH_CYC = 66
) (
  input logic       clk,
  input logic       por_n,
  input logic       bus_en,
  input logic       rst_n_int,
  input logic       pin_drive_low,
  input logic [5:0] rst_status,
  input logic       rst_pin_en,
  input logic       bkgd_pin_en,
  input logic       dbg_mode,
  input logic       sample_mode
);
  int drv_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                      drv_cnt <= 0;
    else if (!pin_drive_low)         drv_cnt <= 0;
    else if (bus_en)                 drv_cnt <= drv_cnt + 1;
  end

  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
    $countones(rst_status) == 1);  // R5
  AST_PIN_EN_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    $past(rst_pin_en) |-> rst_pin_en);  // R2
  AST_STRETCH_LEN: assert property (@(posedge clk) disable iff (!por_n)
    $fell(pin_drive_low) |-> drv_cnt == STRETCH_CYC);  // R4
  AST_DRIVE_NEEDS_EN: assert property (@(posedge clk) disable iff (!por_n)
    pin_drive_low |-> rst_pin_en);  // R4
  AST_DRIVE_HOLDS_RST: assert property (@(posedge clk) disable iff (!por_n)
    pin_drive_low |-> !rst_n_int);  // R10
  AST_MODE_NORMAL: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(rst_n_int) && !$past(sample_mode)) |-> !dbg_mode);  // R8
  AST_BKGD_AT_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_n_int) |-> bkgd_pin_en);  // R6
endmodule

bind rstpin_ctrl rstpin_ctrl_chk #(.STRETCH_CYC(STRETCH_CYC)) chk_i (
  .clk(clk), .por_n(por_n), .bus_en(bus_en), .rst_n_int(rst_n_int),
  .pin_drive_low(pin_drive_low), .rst_status(rst_status), .rst_pin_en(rst_pin_en),
  .bkgd_pin_en(bkgd_pin_en), .dbg_mode(dbg_mode), .sample_mode(sample_mode)
);

// File: tb/rstpin_ctrl_tb.sv
module rstpin_ctrl_tb_top;
  localparam int N = 6;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic bus_en = 1'b1;
  logic int_req = 1'b0;
  logic [2:0] int_code = 3'd0;
  logic dbg_req = 1'b0;
  logic ext_low = 1'b0;
  logic mode_pin = 1'b1;
  logic cfg_wr = 1'b0, cfg_rpe = 1'b0, cfg_bke = 1'b0;
  logic pin_in;
  logic rst_n_int, pin_drive_low, rst_pin_en, bkgd_pin_en, dbg_mode;
  logic [5:0] rst_status;

  int checks = 0, errors = 0, cyc = 0, drv_cnt = 0, bus_pat = 0;

  always #2.5 clk = ~clk;

  // Open-drain net: low if the bench or the block pulls it.
  assign pin_in = !(ext_low || pin_drive_low);

  rstpin_ctrl #(.STRETCH_CYC(N)) dut_i (
    .clk(clk), .por_n(por_n), .bus_en(bus_en), .int_rst_req(int_req),
    .int_rst_code(int_code), .dbg_force_req(dbg_req), .pin_in(pin_in),
    .mode_pin(mode_pin), .cfg_wr(cfg_wr), .cfg_rst_pin_en(cfg_rpe),
    .cfg_bkgd_en(cfg_bke), .rst_n_int(rst_n_int), .pin_drive_low(pin_drive_low),
    .rst_status(rst_status), .rst_pin_en(rst_pin_en), .bkgd_pin_en(bkgd_pin_en),
    .dbg_mode(dbg_mode)
  );

  always @(negedge clk) begin
    cyc++;
    case (bus_pat)
      1:       bus_en = cyc[0];
      2:       bus_en = (cyc % 3) != 0;
      default: bus_en = 1'b1;
    endcase
  end

  always @(posedge clk) if (pin_drive_low && bus_en) drv_cnt++;

  always @(negedge clk) if (cyc > 150000) begin
    errors++;
    $display("FAIL watchdog: actual cycles=%0d expected <150000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_bit(input int code);
    int c = (code >= 2 && code <= 4) ? code : 3;
    return 1 << c;
  endfunction

  task automatic do_por(input logic mlev);
    @(negedge clk);
    por_n = 1'b0; mode_pin = mlev;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_release(output int n);
    n = 0;
    while (!rst_n_int && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic cfg(input logic rpe, input logic bke);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_rpe = rpe; cfg_bke = bke;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic fire(input bit dbg, input bit intr, input int code, output int n);
    @(negedge clk);
    drv_cnt = 0;
    dbg_req = dbg; int_req = intr; int_code = 3'(code);
    @(negedge clk);
    dbg_req = 1'b0; int_req = 1'b0;
    wait_release(n);
  endtask

  initial begin
    int n;
    bit held;
    // R1, R7: power-on with both strap levels
    for (int m = 0; m < 2; m++) begin
      do_por(1'(m));
      chk(rst_n_int == 1'b1, "R1 released", rst_n_int, 1);
      chk(rst_status == 6'b000001, "R1 status", rst_status, 1);
      chk(rst_pin_en == 1'b0, "R1 pin_en", rst_pin_en, 0);
      chk(bkgd_pin_en == 1'b1, "R1 bkgd", bkgd_pin_en, 1);
      chk(dbg_mode == 1'(!m), "R7 por mode", dbg_mode, !m);
    end
    // R1: GPIO mode ignores a low pin
    held = 1'b1;
    @(negedge clk); ext_low = 1'b1;
    repeat (10) begin @(negedge clk); if (!rst_n_int) held = 1'b0; end
    ext_low = 1'b0;
    chk(held, "R1 gpio no reset", held, 1);
    chk(rst_status == 6'b000001, "R1 gpio status", rst_status, 1);
    // R4: reset with pin disabled drives nothing
    fire(1'b0, 1'b1, 2, n);
    chk(drv_cnt == 0, "R4 no drive when disabled", drv_cnt, 0);
    chk(rst_status == 6'b000100, "R5 wdog", rst_status, 4);
    // R6, R2: configuration writes
    cfg(1'b0, 1'b0);
    chk(bkgd_pin_en == 1'b0, "R6 sw clear", bkgd_pin_en, 0);
    chk(rst_pin_en == 1'b0, "R2 still off", rst_pin_en, 0);
    cfg(1'b1, 1'b0);
    chk(rst_pin_en == 1'b1, "R2 set", rst_pin_en, 1);
    cfg(1'b0, 1'b1);
    chk(rst_pin_en == 1'b1, "R2 write zero ignored", rst_pin_en, 1);
    chk(bkgd_pin_en == 1'b1, "R6 sw set", bkgd_pin_en, 1);
    // R4, R5, R6, R8: sweep codes and bus duty patterns
    for (int p = 0; p < 3; p++) begin
      for (int code = 0; code < 8; code++) begin
        bus_pat = p;
        mode_pin = code[0];
        cfg(1'b0, 1'b0);
        fire(1'b0, 1'b1, code, n);
        chk(drv_cnt == N, "R4 stretch", drv_cnt, N);
        chk(rst_status == 6'(exp_bit(code)), "R5 cause", rst_status, exp_bit(code));
        chk(bkgd_pin_en == 1'b1, "R6 set by reset", bkgd_pin_en, 1);
        chk(dbg_mode == 1'b0, "R8 normal mode", dbg_mode, 0);
        repeat (4) @(negedge clk);
        chk(rst_n_int && rst_status == 6'(exp_bit(code)), "R9 own drive not recorded",
            rst_status, exp_bit(code));
      end
    end
    bus_pat = 0;
    // R7: debug force with both strap levels
    for (int m = 0; m < 2; m++) begin
      mode_pin = 1'(m);
      fire(1'b1, 1'b0, 0, n);
      chk(rst_status == 6'b100000, "R5 dbg cause", rst_status, 32);
      chk(drv_cnt == N, "R4 dbg stretch", drv_cnt, N);
      chk(dbg_mode == 1'(!m), "R7 dbg mode", dbg_mode, !m);
    end
    // R11: simultaneous debug and internal request
    mode_pin = 1'b1;
    fire(1'b1, 1'b1, 4, n);
    chk(rst_status == 6'b100000, "R11 priority", rst_status, 32);
    // R3, R8, R9: short external pulse
    mode_pin = 1'b0;
    @(negedge clk); drv_cnt = 0; ext_low = 1'b1;
    repeat (3) @(negedge clk);
    ext_low = 1'b0;
    chk(rst_n_int == 1'b0, "R3 pin reset entered", rst_n_int, 0);
    wait_release(n);
    chk(rst_status == 6'b000010, "R3 pin cause", rst_status, 2);
    chk(drv_cnt == N, "R4 pin stretch", drv_cnt, N);
    chk(dbg_mode == 1'b0, "R8 pin mode", dbg_mode, 0);
    repeat (10) @(negedge clk);
    chk(rst_n_int == 1'b1, "R9 no retrigger", rst_n_int, 1);
    // R10: pin held low long after the stretch
    @(negedge clk); ext_low = 1'b1;
    repeat (40) @(negedge clk);
    chk(rst_n_int == 1'b0, "R10 held by pin", rst_n_int, 0);
    ext_low = 1'b0;
    wait_release(n);
    chk(n >= 2 && n <= 4, "R10 release after pin high", n, 3);
    // R11: requests during reset ignored
    @(negedge clk); int_req = 1'b1; int_code = 3'd2;
    @(negedge clk); int_req = 1'b0; dbg_req = 1'b1; cfg_wr = 1'b1; cfg_bke = 1'b0;
    @(negedge clk); dbg_req = 1'b0; cfg_wr = 1'b0;
    wait_release(n);
    chk(rst_status == 6'b000100, "R11 request in reset ignored", rst_status, 4);
    chk(bkgd_pin_en == 1'b1, "R11 write in reset ignored", bkgd_pin_en, 1);
    // R2: only power-on clears the enable
    do_por(1'b1);
    chk(rst_pin_en == 1'b0, "R2 cleared by por", rst_pin_en, 0);
    chk(rst_status == 6'b000001, "R1 status after por", rst_status, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule